// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Decoder

This block is a small synchronous static memory with a shared data bus. On every rising clock edge it decodes three chip selects, two address strobes, an advance input and the write controls. From these it starts an access, continues an access or ends it, and stores write data with per-byte masking. The read data leaves through a registered output. A drive-enable output tells the bus pad when the block may drive the shared bus. Burst address stepping is not part of this block: a continuation access reuses the address held from the strobe that opened the access.

There are two strobes with different rules. The processor-side strobe always opens a read. A chip select can mask it, and then it is ignored. The controller-side strobe opens either a read or a write, as the write controls decide. Writes can therefore only start through the controller-side strobe or on a continuation cycle after an access has been opened. The internal write qualifier is built from three inputs: an all-lanes write, a byte-write enable and the per-lane selects.

Top module: `sbc_sram_core`

## Requirements
- R1: While `rst_n` is low, `drive_en` is low. After reset no access is open and no read data is pending.
- R2: The device is selected only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. A strobe that opens an access under any other combination is a deselect. It reads nothing, writes nothing, closes the open access, and `drive_en` stays low in the read-data cycle that would follow.
- R3: When `proc_strobe_n`=0 and `sel0_n`=0 and the device is selected, the block opens a read at `addr`, whatever the write controls say. Memory is left unchanged.
- R4: When `sel0_n`=1, a low `proc_strobe_n` is ignored. The cycle is then decoded as if that strobe were high.
- R5: When `ctrl_strobe_n`=0, the device is selected and R3 does not apply, the block opens an access at `addr`. It is a write of `wdata` on that same edge if the internal write is active, and a read otherwise.
- R6: The internal write is active when `all_wr_n`=0, or when `lane_wr_en_n`=0 and at least one bit of `lane_sel_n` is 0. With `all_wr_n`=0 all lanes are written. Otherwise only the lanes i with `lane_sel_n[i]`=0 are written, where lane i is bits 8i+7..8i. All other lanes keep their contents.
- R7: With both strobes inactive and an access open, `advance_n`=0 gives a continuation access at the held address: a write if the internal write is active, otherwise a read. `advance_n`=1 gives no access, and memory is unchanged.
- R8: For a read decoded at edge k, `rdata` takes the addressed word at edge k+1. The word is taken as it stood before any write at edge k+1.
- R9: `drive_en` is high only in the cycle after that load, and only while `out_en_n`=0. It follows `out_en_n` without waiting for a clock edge.
- R10: While the inputs present a write cycle, `drive_en` is low whatever the value of `out_en_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the control state |
| sel0_n | input | 1 | Active-low select; also masks the processor-side strobe |
| sel1 | input | 1 | Active-high select |
| sel2_n | input | 1 | Active-low select |
| proc_strobe_n | input | 1 | Processor-side address strobe, always opens a read |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, opens a read or a write |
| advance_n | input | 1 | Active-low continuation request |
| all_wr_n | input | 1 | Active-low write of all lanes |
| lane_wr_en_n | input | 1 | Active-low enable for byte-lane writes |
| lane_sel_n | input | LANES (4) | Active-low per-lane write selects |
| out_en_n | input | 1 | Active-low output enable, not clocked |
| addr | input | ADDR_W (8) | Word address |
| wdata | input | LANES*LANE_W (32) | Write data |
| rdata | output | LANES*LANE_W (32) | Registered read data |
| drive_en | output | 1 | Permission to drive the shared bus |

## Verification
A write changes memory at the edge where it is decoded. A read shows up in `rdata` one edge after it is decoded. `drive_en` is high during the whole cycle that follows that load. The bench drives each cycle's inputs just after a rising edge. It checks `drive_en` one nanosecond later, before the next edge, against a model state that has not yet been advanced. It then advances its shadow array and pipeline model at the edge, reading before writing, and compares `rdata` one nanosecond after the edge whenever its model says a load took place. The probes of `out_en_n` toggle it in the middle of a read-data cycle, so the check shows that `drive_en` responds without a clock edge.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
   import sbc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4
) (
   input  logic              sel0_n,
   input  logic              sel1,
   input  logic              sel2_n,
   input  logic              proc_strobe_n,
   input  logic              ctrl_strobe_n,
   input  logic              advance_n,
   input  logic              all_wr_n,
   input  logic              lane_wr_en_n,
   input  logic [LANES-1:0]  lane_sel_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic              active_q,
   output op_e               op_next,
   output logic [ADDR_W-1:0] addr_next,
   output logic              active_next,
   output logic [LANES-1:0]  lane_mask
);
   logic selected;
   logic wr_qual;
   logic proc_hit;

   assign selected = !sel0_n && sel1 && !sel2_n;
   // the processor strobe is only seen while sel0_n is low
   assign proc_hit = !proc_strobe_n && !sel0_n;
   assign wr_qual  = !all_wr_n || (!lane_wr_en_n && !(&lane_sel_n));
   assign lane_mask = all_wr_n ? ~lane_sel_n : {LANES{1'b1}};

   always_comb begin
      op_next     = OP_IDLE;
      addr_next   = addr_q;
      active_next = active_q;
      if (proc_hit) begin
         addr_next   = addr;
         active_next = selected;
         op_next     = selected ? OP_READ : OP_IDLE;
      end else if (!ctrl_strobe_n) begin
         addr_next   = addr;
         active_next = selected;
         if (selected) op_next = wr_qual ? OP_WRITE : OP_READ;
      end else if (active_q && !advance_n) begin
         op_next = wr_qual ? OP_WRITE : OP_READ;
      end
   end
endmodule

// File: rtl/sbc_lane_array.sv
module sbc_lane_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                      clk,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [LANES-1:0]          lane_mask,
   input  logic [LANES*LANE_W-1:0]   wdata,
   input  logic                      rd_en,
   input  logic [ADDR_W-1:0]         rd_addr,
   output logic [LANES*LANE_W-1:0]   rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk) begin
         if (wr_en && lane_mask[ln]) mem[wr_addr] <= wdata[ln*LANE_W +: LANE_W];
         if (rd_en) rd_q <= mem[rd_addr];
      end

      assign rdata[ln*LANE_W +: LANE_W] = rd_q;
   end
endmodule

// File: rtl/sbc_out_stage.sv
module sbc_out_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_issue,
   input  logic wr_now,
   input  logic out_en_n,
   output logic rd_valid,
   output logic drive_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= rd_issue;
   end

   // out_en_n is not clocked; a write presented on the inputs forces the bus off
   assign drive_en = rd_valid && !out_en_n && !wr_now;
endmodule

// File: rtl/sbc_sram_core.sv
module sbc_sram_core
   import sbc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sel0_n,
   input  logic                    sel1,
   input  logic                    sel2_n,
   input  logic                    proc_strobe_n,
   input  logic                    ctrl_strobe_n,
   input  logic                    advance_n,
   input  logic                    all_wr_n,
   input  logic                    lane_wr_en_n,
   input  logic [LANES-1:0]        lane_sel_n,
   input  logic                    out_en_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    drive_en
);
   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr_w
      $error("sbc_sram_core: ADDR_W must lie in 1..12");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("sbc_sram_core: LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("sbc_sram_core: LANE_W must be at least 1");
   end

   op_e               op_q, op_next;
   logic [ADDR_W-1:0] addr_q, addr_next;
   logic              active_q, active_next;
   logic [LANES-1:0]  lane_mask;
   logic              rd_valid;
   logic              wr_now;
   logic [DATA_W-1:0] wdata_w;

   sbc_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) dec_i (
      .sel0_n        (sel0_n),
      .sel1          (sel1),
      .sel2_n        (sel2_n),
      .proc_strobe_n (proc_strobe_n),
      .ctrl_strobe_n (ctrl_strobe_n),
      .advance_n     (advance_n),
      .all_wr_n      (all_wr_n),
      .lane_wr_en_n  (lane_wr_en_n),
      .lane_sel_n    (lane_sel_n),
      .addr          (addr),
      .addr_q        (addr_q),
      .active_q      (active_q),
      .op_next       (op_next),
      .addr_next     (addr_next),
      .active_next   (active_next),
      .lane_mask     (lane_mask)
   );

   assign wr_now  = (op_next == OP_WRITE);
   assign wdata_w = wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q     <= OP_IDLE;
         addr_q   <= '0;
         active_q <= 1'b0;
      end else begin
         op_q     <= op_next;
         addr_q   <= addr_next;
         active_q <= active_next;
      end
   end

   sbc_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) arr_i (
      .clk       (clk),
      .wr_en     (wr_now && rst_n),
      .wr_addr   (addr_next),
      .lane_mask (lane_mask),
      .wdata     (wdata_w),
      .rd_en     (op_q == OP_READ),
      .rd_addr   (addr_q),
      .rdata     (rdata)
   );

   sbc_out_stage out_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_issue (op_q == OP_READ),
      .wr_now   (wr_now),
      .out_en_n (out_en_n),
      .rd_valid (rd_valid),
      .drive_en (drive_en)
   );
endmodule

// File: rtl/sbc_sram_core_chk.sv
module sbc_sram_core_chk
   import sbc_pkg::*;
(
   input logic clk,
   input logic rst_n,
   input logic sel0_n,
   input logic sel1,
   input logic sel2_n,
   input logic proc_strobe_n,
   input logic ctrl_strobe_n,
   input logic all_wr_n,
   input logic out_en_n,
   input logic drive_en,
   input logic rd_valid,
   input op_e  op_q
);
   logic chip_on;
   assign chip_on = !sel0_n && sel1 && !sel2_n;

   // R1: reset keeps the bus released
   a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !drive_en);

   // R2: a deselect by the controller strobe leaves the following read-data cycle silent
   a_r2_deselect_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_strobe_n && !chip_on && (proc_strobe_n || sel0_n)) |=> ##1 !drive_en);

   // R8: the load flag follows a decoded read by one edge
   a_r8_load_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_READ) |=> rd_valid);

   a_r8_no_load_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q != OP_READ) |=> !rd_valid);

   // R9: output enable high means no drive
   a_r9_oe_gates_drive: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> !drive_en);

   // R10: an all-lane write opened by the controller strobe forces drive off
   a_r10_write_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_strobe_n && !ctrl_strobe_n && chip_on && !all_wr_n) |-> !drive_en);
endmodule

bind sbc_sram_core sbc_sram_core_chk chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .sel0_n        (sel0_n),
   .sel1          (sel1),
   .sel2_n        (sel2_n),
   .proc_strobe_n (proc_strobe_n),
   .ctrl_strobe_n (ctrl_strobe_n),
   .all_wr_n      (all_wr_n),
   .out_en_n      (out_en_n),
   .drive_en      (drive_en),
   .rd_valid      (rd_valid),
   .op_q          (op_q)
);

// File: tb/sbc_sram_core_tb_top.sv
module sbc_sram_core_tb_top;
   localparam int AW = 8;
   localparam int LN = 4;
   localparam int LW = 8;
   localparam int DW = LN * LW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, sel0_n, sel1, sel2_n, proc_strobe_n, ctrl_strobe_n, advance_n;
   logic all_wr_n, lane_wr_en_n, out_en_n, drive_en;
   logic [LN-1:0] lane_sel_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata, rdata;

   sbc_sram_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (.*);

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   logic [DW-1:0] shadow [1 << AW];
   int            m_op_q = 0;     // 0 idle, 1 read, 2 write
   logic [AW-1:0] m_addr_q = '0;
   bit            m_active = 0;
   bit            m_rdv = 0;
   logic [DW-1:0] m_rdata = '0;

   function automatic logic [DW-1:0] f_mask(logic gn, logic [LN-1:0] lsn);
      logic [DW-1:0] m = '0;
      for (int i = 0; i < LN; i++)
         if (!gn || !lsn[i]) m[i*LW +: LW] = '1;
      return m;
   endfunction

   function automatic bit f_wr(logic gn, logic bn, logic [LN-1:0] lsn);
      return !gn || (!bn && (lsn != '1));
   endfunction

   task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic cyc(string tag, bit s0n, bit s1, bit s2n, bit pn, bit cn, bit an,
                      bit gn, bit bn, logic [LN-1:0] lsn, bit oen,
                      logic [AW-1:0] a, logic [DW-1:0] d);
      bit sel, wi, nact;
      int op;
      logic [AW-1:0] na;
      sel0_n = s0n; sel1 = s1; sel2_n = s2n; proc_strobe_n = pn; ctrl_strobe_n = cn;
      advance_n = an; all_wr_n = gn; lane_wr_en_n = bn; lane_sel_n = lsn;
      out_en_n = oen; addr = a; wdata = d;
      sel = !s0n && s1 && !s2n;
      wi = f_wr(gn, bn, lsn);
      nact = m_active;
      na = m_addr_q;
      op = 0;
      if (!pn && !s0n) begin
         op = sel ? 1 : 0; na = a; nact = sel;
      end else if (!cn) begin
         op = sel ? (wi ? 2 : 1) : 0; na = a; nact = sel;
      end else if (m_active && !an) begin
         op = wi ? 2 : 1;
      end
      #1;
      chk((op == 2) ? "R10" : "R9", "drive_en", DW'(drive_en),
          DW'(m_rdv && !oen && op != 2));
      @(posedge clk);
      if (m_op_q == 1) begin
         m_rdata = shadow[m_addr_q];
         m_rdv = 1;
      end else begin
         m_rdv = 0;
      end
      if (op == 2) shadow[na] = (shadow[na] & ~f_mask(gn, lsn)) | (d & f_mask(gn, lsn));
      m_op_q = op; m_addr_q = na; m_active = nact;
      #1;
      if (m_rdv) chk(tag, "rdata", rdata, m_rdata);
   endtask

   task automatic idle(string tag);
      cyc(tag, 1, 0, 1, 1, 1, 1, 1, 1, '1, 0, '0, '0);
   endtask

   // read through the processor strobe, then let the data load
   task automatic rd(string tag, logic [AW-1:0] a);
      cyc(tag, 0, 1, 0, 0, 1, 1, 0, 0, 4'h0, 0, a, 32'hDEAD_BEEF);
      idle(tag);
   endtask

   task automatic wr(string tag, logic [AW-1:0] a, logic [DW-1:0] d, bit gn, bit bn, logic [LN-1:0] lsn);
      cyc(tag, 0, 1, 0, 1, 0, 1, gn, bn, lsn, 1, a, d);
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1C0FFEE));
      rst_n = 0;
      sel0_n = 1; sel1 = 0; sel2_n = 1; proc_strobe_n = 1; ctrl_strobe_n = 1;
      advance_n = 1; all_wr_n = 1; lane_wr_en_n = 1; lane_sel_n = '1;
      out_en_n = 0; addr = '0; wdata = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "drive_en in reset", DW'(drive_en), '0);
      rst_n = 1;
      @(posedge clk); #1;
      chk("R1", "drive_en after reset", DW'(drive_en), '0);

      // fill every word with a known pattern (R5, controller-strobe writes)
      for (int i = 0; i < (1 << AW); i++)
         wr("R5", AW'(i), {8'(i), 8'(i ^ 8'h5A), 8'(~i), 8'(i + 3)}, 0, 1, '1);
      rd("R5", 8'd7);

      // R6: full write, then partial lane writes
      wr("R6", 8'd5, 32'h1122_3344, 0, 1, '1);
      rd("R6", 8'd5);
      wr("R6", 8'd5, 32'hAABB_CCDD, 1, 0, 4'b0101);
      rd("R6", 8'd5);
      wr("R6", 8'd5, 32'h9999_9999, 1, 1, 4'b0000);   // lane enable off: no write, read instead
      idle("R6");
      rd("R6", 8'd5);

      // R3: processor strobe with writes requested still reads
      cyc("R3", 0, 1, 0, 0, 0, 1, 0, 0, 4'h0, 1, 8'd9, 32'h0BAD_0BAD);
      idle("R3");
      rd("R3", 8'd9);

      // R4: processor strobe masked by sel0_n; the open access continues as a write
      rd("R4", 8'd20);
      cyc("R4", 1, 1, 0, 0, 1, 0, 0, 1, '1, 1, 8'd33, 32'hCAFE_F00D);
      rd("R4", 8'd20);
      rd("R4", 8'd33);

      // R2: deselect by the controller strobe closes the access
      rd("R2", 8'd40);
      cyc("R2", 0, 0, 0, 1, 0, 1, 0, 1, '1, 0, 8'd41, 32'h1357_9BDF);
      cyc("R2", 0, 1, 0, 1, 1, 0, 0, 1, '1, 0, 8'd0, 32'h2468_ACE0);
      rd("R2", 8'd40);
      rd("R2", 8'd41);

      // R7: suspend with write controls active, then continuation writes and reads
      wr("R7", 8'd60, 32'h6060_6060, 0, 1, '1);
      cyc("R7", 0, 1, 0, 1, 1, 1, 0, 1, '1, 1, 8'd0, 32'hFFFF_0000);
      cyc("R7", 0, 1, 0, 1, 1, 0, 1, 0, 4'b1110, 1, 8'd0, 32'h0000_00EE);
      cyc("R7", 0, 1, 0, 1, 1, 0, 1, 1, '1, 0, 8'd0, '0);
      idle("R7");
      rd("R7", 8'd60);

      // R9: output enable toggled inside a read-data cycle without a clock edge
      rd("R9", 8'd70);
      cyc("R9", 1, 0, 1, 1, 1, 1, 1, 1, '1, 0, '0, '0);
      cyc("R9", 1, 0, 1, 1, 1, 1, 1, 1, '1, 0, '0, '0);
      cyc("R9", 0, 1, 0, 0, 1, 1, 1, 1, '1, 0, 8'd71, '0);
      idle("R9");
      out_en_n = 1; #1;
      chk("R9", "drive_en oe high", DW'(drive_en), '0);
      out_en_n = 0; #1;
      chk("R9", "drive_en oe low", DW'(drive_en), 32'd1);
      idle("R9");

      // R10: write presented during a read-data cycle with oe low
      rd("R10", 8'd80);
      cyc("R10", 0, 1, 0, 1, 0, 1, 0, 1, '1, 0, 8'd81, 32'h8181_8181);
      rd("R10", 8'd81);

      // R8: read and write on the same edge to the same word returns the old word
      cyc("R8", 0, 1, 0, 0, 1, 1, 1, 1, '1, 0, 8'd90, '0);
      cyc("R8", 0, 1, 0, 1, 0, 1, 0, 1, '1, 0, 8'd90, 32'h9090_9090);
      idle("R8");
      rd("R8", 8'd90);

      // constrained random traffic
      for (int n = 0; n < 3000; n++) begin
         cyc("R8", ($urandom % 8) == 0, ($urandom % 8) != 0, ($urandom % 8) == 0,
             ($urandom % 3) != 0, ($urandom % 3) != 0, ($urandom % 2) != 0,
             ($urandom % 4) != 0, ($urandom % 2) != 0, LN'($urandom),
             ($urandom % 5) == 0, AW'($urandom), $urandom);
      end

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule